// File: doc/BRIEF.md
# Four-Byte Tester Command Decoder

This block sits behind a serial receiver in a radiation-test controller. It receives bytes one at a time and groups them into four-byte command words. The first byte is an opcode and the next three are data bytes D0, D1 and D2. When the fourth byte arrives, the word is decoded. The result is a set of one-clock action pulses, a few persistent mode bits, and a small bank of setting registers that drive the rest of the tester. Those registers hold the clock divider, the two address bounds for error injection, the address at which scrubbing stops, and the control and mask words.

The decoder guards a few orderings. Scrubbing can only be turned on once the configuration sequencer reports a finished configuration. Error injection only reaches its output while scrubbing is on. A device-reset command produces an active-low reset that lasts several clocks. If the byte stream stalls partway through a word, the bytes already received are thrown away, so the next byte is treated as a fresh opcode. An opcode outside the map has no effect except for a one-clock error flag.

Top module: `cmd_word_decoder`

## Requirements
- R1: A command is acted on only when its fourth byte is accepted (byte order: opcode, D0, D1, D2). Its effects are visible in the clock cycle after the edge that accepts that byte. No output changes after only three bytes.
- R2: Opcode 0x02 pulses `test_start_o`, 0x04 pulses `cfg_start_o` and 0x81 pulses `dl_start_o`. Each pulse is high for exactly one clock.
- R3: Opcode 0x01 drives `dev_rst_no` low for exactly RST_CYCLES clocks (default 4, never fewer than 3). It also clears the scrub, readback and injection-enable bits.
- R4: Opcode 0x06 sets `scrub_on_o` only if `cfg_done_i` is high in the cycle the word completes. Otherwise the opcode is ignored.
- R5: Opcode 0x05 sets `rdbk_on_o`, which stays high until a device-reset command.
- R6: Opcode 0x0E sets an injection enable bit. `inj_on_o` is high only while both that bit and `scrub_on_o` are high.
- R7: Opcode 0xA0 loads `clk_div_o` from D0. D1 and D2 have no effect.
- R8: Opcodes 0x7A (upper injection bound), 0x79 (lower injection bound) and 0x7B (scrub end) each load a 20-bit address {D0[3:0], D1, D2}. D0[7:4] is ignored.
- R9: After reset the outputs are as follows. The lower bound is 0x00800, the upper bound 0x70000, the scrub end 0xFFFFF and the divider 0x01. `dev_rst_no` is high, and all pulses and mode bits are low.
- R10: Opcode 0x89 loads `ctrl_o` = {D2, D1, D0, 0x01} and 0x8A loads `mask_o` = {D2, D1, D0, 0xFF}. Bits [7:0] are fixed by parameters and cannot be written. The upper 24 bits reset to zero.
- R11: An opcode not listed above pulses `bad_op_o` for one clock and changes no other output.
- R12: If TIMEOUT (65536) consecutive clock edges pass without a byte while a word is partly received, that partial word is discarded. A gap of TIMEOUT-1 edges keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_vld_i | input | 1 | Received byte is valid this cycle |
| rx_byte_i | input | 8 | Received byte |
| cfg_done_i | input | 1 | Configuration sequencer reports a completed configuration |
| dev_rst_no | output | 1 | Active-low device reset |
| test_start_o | output | 1 | Start-test pulse |
| cfg_start_o | output | 1 | Start-configuration pulse |
| dl_start_o | output | 1 | Start configuration-data download pulse |
| scrub_on_o | output | 1 | Scrubbing enabled |
| rdbk_on_o | output | 1 | Readback enabled |
| inj_on_o | output | 1 | Error injection active |
| bad_op_o | output | 1 | Unknown-opcode pulse |
| clk_div_o | output | 8 | Clock divider setting |
| inj_hi_o | output | 20 | Upper error-injection address bound |
| inj_lo_o | output | 20 | Lower error-injection address bound |
| scrub_end_o | output | 20 | Last address to scrub |
| ctrl_o | output | 32 | Control word |
| mask_o | output | 32 | Mask word |

## Verification
The stall timeout is the hardest behaviour to reach from the ports. It only shows up after tens of thousands of quiet clocks, and only in the middle of a word. The bench sends a lone opcode, waits exactly TIMEOUT-1 idle cycles, and then sends a full word. Its bytes are chosen so that a kept partial and a dropped partial write different registers with different values. It then repeats this with one idle cycle fewer, which must keep the partial word. Scrub gating is reached by toggling `cfg_done_i` between two scrub commands, with an injection command placed between them.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int BYTE_W    = 8;
  localparam int CMD_BYTES = 4;
  localparam int ADDR_W    = 20;
  localparam int NUM_ADDR  = 3;

  typedef enum logic [BYTE_W-1:0] {
    OP_RST   = 8'h01,
    OP_TEST  = 8'h02,
    OP_CFG   = 8'h04,
    OP_RDBK  = 8'h05,
    OP_SCRUB = 8'h06,
    OP_INJ   = 8'h0E,
    OP_LO    = 8'h79,
    OP_HI    = 8'h7A,
    OP_END   = 8'h7B,
    OP_DL    = 8'h81,
    OP_CTRL  = 8'h89,
    OP_MASK  = 8'h8A,
    OP_DIV   = 8'hA0
  } op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] d0;
    logic [BYTE_W-1:0] d1;
    logic [BYTE_W-1:0] d2;
  } cmd_word_t;
endpackage

// File: rtl/cmd_frame_asm.sv
module cmd_frame_asm
  import cmd_dec_pkg::*;
#(
  parameter int TIMEOUT = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              word_vld_o,
  output cmd_word_t         word_o
);
  localparam int CNT_W  = $clog2(CMD_BYTES);
  localparam int HOLD_N = CMD_BYTES - 1;
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_BYTES - 1);
  localparam logic [TO_W-1:0]  TO_LIM = TO_W'(TIMEOUT - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [TO_W-1:0]   idle_q;
  logic [BYTE_W-1:0] hold_q [HOLD_N];

  assign word_vld_o = byte_vld_i && (cnt_q == LAST);
  assign word_o     = {hold_q[0], hold_q[1], hold_q[2], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= '0;
      for (int i = 0; i < HOLD_N; i++) hold_q[i] <= '0;
    end else if (byte_vld_i) begin
      idle_q <= '0;
      if (cnt_q == LAST) begin
        cnt_q <= '0;
      end else begin
        hold_q[cnt_q[1:0]] <= byte_i;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (cnt_q != '0) begin
      // stalled partial word: drop after TIMEOUT empty edges
      if (idle_q == TO_LIM) begin
        cnt_q  <= '0;
        idle_q <= '0;
      end else begin
        idle_q <= idle_q + TO_W'(1);
      end
    end
  end
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import cmd_dec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] DIV_RST = 8'h01,
  parameter logic [ADDR_W-1:0] LO_RST  = 20'h00800,
  parameter logic [ADDR_W-1:0] HI_RST  = 20'h70000,
  parameter logic [ADDR_W-1:0] END_RST = 20'hFFFFF,
  parameter logic [BYTE_W-1:0] CTRL_B0 = 8'h01,
  parameter logic [BYTE_W-1:0] MASK_B0 = 8'hFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_vld_i,
  input  cmd_word_t           word_i,
  input  logic                cfg_done_i,
  output logic                rst_req_o,
  output logic                test_start_o,
  output logic                cfg_start_o,
  output logic                dl_start_o,
  output logic                scrub_on_o,
  output logic                rdbk_on_o,
  output logic                inj_on_o,
  output logic                bad_op_o,
  output logic [BYTE_W-1:0]   div_o,
  output logic [ADDR_W-1:0]   hi_o,
  output logic [ADDR_W-1:0]   lo_o,
  output logic [ADDR_W-1:0]   end_o,
  output logic [4*BYTE_W-1:0] ctrl_o,
  output logic [4*BYTE_W-1:0] mask_o
);
  localparam int REG_W = 3 * BYTE_W;
  localparam int NIB_W = ADDR_W - 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] ADDR_OP  [NUM_ADDR] = '{OP_HI, OP_LO, OP_END};
  localparam logic [ADDR_W-1:0] ADDR_RST [NUM_ADDR] = '{HI_RST, LO_RST, END_RST};

  logic [NUM_ADDR*ADDR_W-1:0] addr_flat;
  logic scrub_q, rdbk_q, inj_q;
  logic rst_p, test_p, cfg_p, dl_p, bad_p;
  logic [BYTE_W-1:0] div_q;
  logic [REG_W-1:0]  ctrl_q, mask_q;

  function automatic logic op_known(input logic [BYTE_W-1:0] op);
    case (op)
      OP_RST, OP_TEST, OP_CFG, OP_RDBK, OP_SCRUB, OP_INJ, OP_LO, OP_HI,
      OP_END, OP_DL, OP_CTRL, OP_MASK, OP_DIV: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  for (genvar k = 0; k < NUM_ADDR; k++) begin : g_addr
    logic [ADDR_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= ADDR_RST[k];
      else if (word_vld_i && word_i.op == ADDR_OP[k])
        q <= {word_i.d0[NIB_W-1:0], word_i.d1, word_i.d2};
    end
    assign addr_flat[k*ADDR_W +: ADDR_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {rst_p, test_p, cfg_p, dl_p, bad_p} <= '0;
      {scrub_q, rdbk_q, inj_q} <= '0;
      div_q  <= DIV_RST;
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      {rst_p, test_p, cfg_p, dl_p, bad_p} <= '0;
      if (word_vld_i) begin
        if (!op_known(word_i.op)) bad_p <= 1'b1;
        case (word_i.op)
          OP_RST: begin
            rst_p <= 1'b1;
            {scrub_q, rdbk_q, inj_q} <= '0;
          end
          OP_TEST:  test_p <= 1'b1;
          OP_CFG:   cfg_p  <= 1'b1;
          OP_DL:    dl_p   <= 1'b1;
          OP_SCRUB: if (cfg_done_i) scrub_q <= 1'b1;
          OP_RDBK:  rdbk_q <= 1'b1;
          OP_INJ:   inj_q  <= 1'b1;
          OP_DIV:   div_q  <= word_i.d0;
          OP_CTRL:  ctrl_q <= {word_i.d2, word_i.d1, word_i.d0};
          OP_MASK:  mask_q <= {word_i.d2, word_i.d1, word_i.d0};
          default: ;
        endcase
      end
    end
  end

  assign rst_req_o    = rst_p;
  assign test_start_o = test_p;
  assign cfg_start_o  = cfg_p;
  assign dl_start_o   = dl_p;
  assign bad_op_o     = bad_p;
  assign scrub_on_o   = scrub_q;
  assign rdbk_on_o    = rdbk_q;
  assign inj_on_o     = inj_q & scrub_q;
  assign div_o        = div_q;
  assign hi_o         = addr_flat[0*ADDR_W +: ADDR_W];
  assign lo_o         = addr_flat[1*ADDR_W +: ADDR_W];
  assign end_o        = addr_flat[2*ADDR_W +: ADDR_W];
  assign ctrl_o       = {ctrl_q, CTRL_B0};
  assign mask_o       = {mask_q, MASK_B0};

  assert_pulse_after_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_p | test_p | cfg_p | dl_p | bad_p) |-> $past(word_vld_i));
  assert_pulse_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_p, test_p, cfg_p, dl_p, bad_p}));
  assert_test_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_p |=> !test_p);
  assert_scrub_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scrub_q) |-> $past(cfg_done_i));
  assert_inj_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inj_on_o) |-> $past(word_vld_i));
  assert_addr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(word_vld_i) |-> $stable(addr_flat));
  assert_badop_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_p |=> !bad_p);
endmodule

// File: rtl/dev_rst_gen.sv
module dev_rst_gen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic dev_rst_no
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam int RW = $clog2(RST_CYCLES + 2);
  localparam int MIN_LOW = 3;

  logic [CW-1:0] cnt_q;
  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (req_i)        cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign dev_rst_no = (cnt_q == '0);

  // run length of the low phase, for the checker only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_run_q <= '0;
    else if (dev_rst_no)                  low_run_q <= '0;
    else if (low_run_q != {RW{1'b1}})     low_run_q <= low_run_q + RW'(1);
  end

  assert_rst_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dev_rst_no) |-> (int'(low_run_q) >= MIN_LOW));
endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
  import cmd_dec_pkg::*;
#(
  parameter int TIMEOUT    = 65536,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_vld_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        cfg_done_i,
  output logic        dev_rst_no,
  output logic        test_start_o,
  output logic        cfg_start_o,
  output logic        dl_start_o,
  output logic        scrub_on_o,
  output logic        rdbk_on_o,
  output logic        inj_on_o,
  output logic        bad_op_o,
  output logic [7:0]  clk_div_o,
  output logic [19:0] inj_hi_o,
  output logic [19:0] inj_lo_o,
  output logic [19:0] scrub_end_o,
  output logic [31:0] ctrl_o,
  output logic [31:0] mask_o
);
  logic      word_vld;
  cmd_word_t word;
  logic      rst_req;

  cmd_frame_asm #(.TIMEOUT(TIMEOUT)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (rx_vld_i),
    .byte_i     (rx_byte_i),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  cmd_exec u_exec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_vld_i   (word_vld),
    .word_i       (word),
    .cfg_done_i   (cfg_done_i),
    .rst_req_o    (rst_req),
    .test_start_o (test_start_o),
    .cfg_start_o  (cfg_start_o),
    .dl_start_o   (dl_start_o),
    .scrub_on_o   (scrub_on_o),
    .rdbk_on_o    (rdbk_on_o),
    .inj_on_o     (inj_on_o),
    .bad_op_o     (bad_op_o),
    .div_o        (clk_div_o),
    .hi_o         (inj_hi_o),
    .lo_o         (inj_lo_o),
    .end_o        (scrub_end_o),
    .ctrl_o       (ctrl_o),
    .mask_o       (mask_o)
  );

  dev_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (rst_req),
    .dev_rst_no (dev_rst_no)
  );
endmodule

// File: tb/cmd_word_decoder_test.sv
`timescale 1ns/1ps
module cmd_word_decoder_test;
  localparam int TO = 65536;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_vld_i = 1'b0;
  logic [7:0] rx_byte_i = '0;
  logic cfg_done_i = 1'b0;
  logic dev_rst_no, test_start_o, cfg_start_o, dl_start_o;
  logic scrub_on_o, rdbk_on_o, inj_on_o, bad_op_o;
  logic [7:0] clk_div_o;
  logic [19:0] inj_hi_o, inj_lo_o, scrub_end_o;
  logic [31:0] ctrl_o, mask_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmd_word_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_vld_i(rx_vld_i), .rx_byte_i(rx_byte_i),
    .cfg_done_i(cfg_done_i), .dev_rst_no(dev_rst_no), .test_start_o(test_start_o),
    .cfg_start_o(cfg_start_o), .dl_start_o(dl_start_o), .scrub_on_o(scrub_on_o),
    .rdbk_on_o(rdbk_on_o), .inj_on_o(inj_on_o), .bad_op_o(bad_op_o),
    .clk_div_o(clk_div_o), .inj_hi_o(inj_hi_o), .inj_lo_o(inj_lo_o),
    .scrub_end_o(scrub_end_o), .ctrl_o(ctrl_o), .mask_o(mask_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_vld_i = 1'b1;
    rx_byte_i = b;
    @(negedge clk);
    rx_vld_i = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] op, d0, d1, d2);
    send_byte(op); send_byte(d0); send_byte(d1); send_byte(d2);
  endtask

  task automatic t_reset_state;
    chk("R9 dev_rst_no", 32'(dev_rst_no), 32'd1);
    chk("R9 inj_lo", 32'(inj_lo_o), 32'h00800);
    chk("R9 inj_hi", 32'(inj_hi_o), 32'h70000);
    chk("R9 scrub_end", 32'(scrub_end_o), 32'hFFFFF);
    chk("R9 clk_div", 32'(clk_div_o), 32'h01);
    chk("R9 modes", 32'({scrub_on_o, rdbk_on_o, inj_on_o, bad_op_o}), 32'd0);
    chk("R10 ctrl reset", ctrl_o, 32'h0000_0001);
    chk("R10 mask reset", mask_o, 32'h0000_00FF);
  endtask

  task automatic t_pulses;
    send_byte(8'h02); send_byte(8'h00); send_byte(8'h00);
    chk("R1 no action after three bytes", 32'(test_start_o), 32'd0);
    send_byte(8'h00);
    chk("R2 test_start pulse", 32'(test_start_o), 32'd1);
    @(negedge clk);
    chk("R2 test_start one clock", 32'(test_start_o), 32'd0);
    send_cmd(8'h04, 8'h00, 8'h00, 8'h00);
    chk("R2 cfg_start pulse", 32'({cfg_start_o, test_start_o, dl_start_o}), 32'b100);
    send_cmd(8'h81, 8'h00, 8'h00, 8'h00);
    chk("R2 dl_start pulse", 32'({dl_start_o, cfg_start_o}), 32'b10);
  endtask

  task automatic t_regs;
    send_cmd(8'hA0, 8'h37, 8'hAA, 8'hBB);
    chk("R7 clk_div from D0", 32'(clk_div_o), 32'h37);
    send_cmd(8'h7A, 8'hF3, 8'h45, 8'h67);
    chk("R8 upper bound, D0 top nibble ignored", 32'(inj_hi_o), 32'h34567);
    send_cmd(8'h79, 8'h0A, 8'hBC, 8'hDE);
    chk("R8 lower bound", 32'(inj_lo_o), 32'hABCDE);
    chk("R8 upper bound kept", 32'(inj_hi_o), 32'h34567);
    send_cmd(8'h7B, 8'h51, 8'h23, 8'h45);
    chk("R8 scrub end", 32'(scrub_end_o), 32'h12345);
    send_cmd(8'h89, 8'h11, 8'h22, 8'h33);
    chk("R10 ctrl", ctrl_o, 32'h3322_1101);
    send_cmd(8'h8A, 8'h44, 8'h55, 8'h66);
    chk("R10 mask", mask_o, 32'h6655_44FF);
  endtask

  task automatic t_scrub;
    cfg_done_i = 1'b0;
    send_cmd(8'h06, 8'h00, 8'h00, 8'h00);
    chk("R4 scrub refused before config done", 32'(scrub_on_o), 32'd0);
    send_cmd(8'h0E, 8'h00, 8'h00, 8'h00);
    chk("R6 inject held off without scrub", 32'(inj_on_o), 32'd0);
    cfg_done_i = 1'b1;
    send_cmd(8'h06, 8'h00, 8'h00, 8'h00);
    chk("R4 scrub accepted", 32'(scrub_on_o), 32'd1);
    chk("R6 inject active with scrub", 32'(inj_on_o), 32'd1);
    send_cmd(8'h05, 8'h00, 8'h00, 8'h00);
    chk("R5 readback on", 32'(rdbk_on_o), 32'd1);
  endtask

  task automatic t_dev_reset;
    int lows = 0;
    send_cmd(8'h01, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 8; i++) begin
      if (!dev_rst_no) lows++;
      @(negedge clk);
    end
    chk("R3 device reset low length", 32'(lows), 32'd4);
    chk("R3 modes cleared", 32'({scrub_on_o, rdbk_on_o, inj_on_o}), 32'd0);
  endtask

  task automatic t_bad_op;
    send_cmd(8'h55, 8'h01, 8'h02, 8'h03);
    chk("R11 bad_op pulse", 32'(bad_op_o), 32'd1);
    chk("R11 no side pulses", 32'({test_start_o, cfg_start_o, dl_start_o, dev_rst_no}), 32'b0001);
    @(negedge clk);
    chk("R11 bad_op one clock", 32'(bad_op_o), 32'd0);
    chk("R11 divider untouched", 32'(clk_div_o), 32'h37);
    chk("R11 ctrl untouched", ctrl_o, 32'h3322_1101);
  endtask

  task automatic t_timeout;
    send_byte(8'h7A);
    repeat (TO - 1) @(negedge clk);
    send_cmd(8'h79, 8'h12, 8'h34, 8'h56);
    chk("R12 stale partial dropped, lower bound", 32'(inj_lo_o), 32'h23456);
    chk("R12 stale partial dropped, upper bound", 32'(inj_hi_o), 32'h34567);
    send_byte(8'h7B);
    repeat (TO - 2) @(negedge clk);
    send_byte(8'h0A); send_byte(8'h0B); send_byte(8'h0C);
    chk("R12 partial kept within window", 32'(scrub_end_o), 32'hA0B0C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_pulses();
    t_regs();
    t_scrub();
    t_dev_reset();
    t_bad_op();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule